// File: doc/BRIEF.md
# Flicker Sampling Timing Sequencer

This block sets the sampling rhythm for a light-flicker measurement engine. It counts ticks from the modulator clock, which arrive as a single-cycle enable, and groups them into sample periods. It then groups the sample periods into measurement frames. The block raises a one-cycle sample strobe at the end of each sample period. It marks where each frame starts and where each frame ends. The timing comes from a small register file with two possible sources. A time-select field can pick one of three fixed presets. When the select is set to custom, the user-written sample count and 10-bit period are used instead.

When a preset is written, the stored period and sample-count fields are overwritten with that preset's values. All timing registers are frozen while both the power bit and the flicker-enable bit are set. The largest sample count turns into an endless stream when three other settings are all active: streaming mode, routing of flicker data to the FIFO, and a non-zero FIFO mode. Clearing the power bit stops the sequence and clears the flicker enable. The effective register values are brought out continuously so that a register interface can read them back.

Top module: `flk_timing_seq`

## Requirements
- R1: Writing address 1 stores the time select in bits[1:0] and the count code in bits[3:2]. A select of 0, 1 or 2 forces the count code to 0 (128 samples). The same write loads the period with 143, 287 or 575 respectively, overwriting any earlier user value.
- R2: With time select 3, the count code written in bits[3:2] is kept. The 10-bit period reads back as (address 3 bits[1:0]) × 256 + (address 2 bits[7:0]).
- R3: While running, the sample strobe is high for exactly one cycle per (period + 1) modulator ticks. It appears in the cycle after the edge that took the final tick of the sample period.
- R4: A frame holds 128 × 2^code samples. Frame done is high in the same cycle as the strobe of the frame's last sample, so a frame lasts samples × (period + 1) ticks.
- R5: Frame start is high in the first cycle after the sequence begins running. It is also high in the same cycle as every frame done, which marks the next frame.
- R6: Address 4 holds streaming mode in bit0, FIFO data routing in bit1 and FIFO mode in bits[4:2]. The unlimited flag is set only when code is 3, streaming and routing are both on, and FIFO mode is non-zero. While the flag is set, frame done never fires. If any one of these conditions is missing, code 3 gives 1024-sample frames.
- R7: While address 0 bit0 (power) and bit1 (flicker enable) are both set, writes to addresses 1, 2 and 3 leave every timing readback unchanged. Such writes take effect again once the flicker enable is cleared.
- R8: A write to address 0 with bit0 clear also clears the flicker enable, whatever bit1 holds. When not running, modulator ticks produce no strobe, start or done.
- R9: After reset the time select is 1, the period is 287, the count code is 0, both enables are clear and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (0 enable, 1 timing, 2 period low, 3 period high, 4 mode) |
| cfg_wdata | input | 8 | Register write data |
| mod_tick | input | 1 | Modulator clock enable, one tick per cycle when high |
| sample_strobe | output | 1 | One-cycle pulse at the end of each sample period |
| frame_start | output | 1 | One-cycle pulse marking the first sample period of a frame |
| frame_done | output | 1 | One-cycle pulse with the last sample of a frame |
| rb_time_sel | output | 2 | Effective time select |
| rb_count_code | output | 2 | Effective sample-count code |
| rb_period | output | 10 | Effective per-sample period |
| rb_pwr | output | 1 | Power bit |
| rb_flk_en | output | 1 | Flicker enable bit |
| rb_unlimited | output | 1 | Free-running frame condition |

## Verification
A tick counter stuck at the wrong state, or compared against the wrong period, moves the sample strobe away from the (period + 1) grid. The bench catches this at the first strobe of a run. A sample counter with a wrong last index puts frame done in the wrong place. For small user periods this is seen within one frame of a few hundred ticks; for the 50 ms preset it is seen at tick 18432. Errors in preset decoding, write locking or enable clearing corrupt the readback fields. These show up on the cycle after the offending write.

// File: rtl/flk_timing_pkg.sv
package flk_timing_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    TSEL_FAST = 2'd0,
    TSEL_MID  = 2'd1,
    TSEL_SLOW = 2'd2,
    TSEL_USER = 2'd3
  } tsel_e;

  typedef enum logic [ADDR_W-1:0] {
    RA_ENABLE = 3'd0,
    RA_TIMING = 3'd1,
    RA_PER_LO = 3'd2,
    RA_PER_HI = 3'd3,
    RA_MODE   = 3'd4
  } reg_addr_e;

endpackage

// File: rtl/flk_cfg_regs.sv
module flk_cfg_regs
  import flk_timing_pkg::*;
#(
  parameter int PERIOD_W = 10,
  parameter int LO_W     = 8,
  parameter int CODE_W   = 2,
  parameter int FMODE_W  = 3,
  parameter int DATA_W   = 8,
  parameter int BASE_P1  = 144
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                pwr_q,
  output logic                flk_q,
  output tsel_e               sel_q,
  output logic [CODE_W-1:0]   code_q,
  output logic [PERIOD_W-1:0] period_q,
  output logic                stream_q,
  output logic                map_q,
  output logic [FMODE_W-1:0]  fmode_q
);

  localparam int HI_W = PERIOD_W - LO_W;
  localparam logic [PERIOD_W-1:0] RST_PERIOD = PERIOD_W'((BASE_P1 << 1) - 1);

  function automatic logic [PERIOD_W-1:0] preset_period(input logic [1:0] s);
    int p1;
    p1 = BASE_P1 << s;
    return PERIOD_W'(p1 - 1);
  endfunction

  logic                pwr_d, flk_d, stream_d, map_d;
  tsel_e               sel_d;
  logic [CODE_W-1:0]   code_d;
  logic [PERIOD_W-1:0] period_d;
  logic [FMODE_W-1:0]  fmode_d;
  logic                locked;

  assign locked = pwr_q & flk_q;

  always_comb begin
    pwr_d    = pwr_q;
    flk_d    = flk_q;
    sel_d    = sel_q;
    code_d   = code_q;
    period_d = period_q;
    stream_d = stream_q;
    map_d    = map_q;
    fmode_d  = fmode_q;
    if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        RA_ENABLE: begin
          pwr_d = wr_data[0];
          flk_d = wr_data[0] & wr_data[1];
        end
        RA_TIMING: begin
          if (!locked) begin
            sel_d = tsel_e'(wr_data[1:0]);
            if (tsel_e'(wr_data[1:0]) == TSEL_USER) begin
              code_d = wr_data[CODE_W+1:2];
            end else begin
              code_d   = '0;
              period_d = preset_period(wr_data[1:0]);
            end
          end
        end
        RA_PER_LO: begin
          if (!locked) period_d[LO_W-1:0] = wr_data[LO_W-1:0];
        end
        RA_PER_HI: begin
          if (!locked) period_d[PERIOD_W-1:LO_W] = wr_data[HI_W-1:0];
        end
        RA_MODE: begin
          stream_d = wr_data[0];
          map_d    = wr_data[1];
          fmode_d  = wr_data[FMODE_W+1:2];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q    <= 1'b0;
      flk_q    <= 1'b0;
      sel_q    <= TSEL_MID;
      code_q   <= '0;
      period_q <= RST_PERIOD;
      stream_q <= 1'b0;
      map_q    <= 1'b0;
      fmode_q  <= '0;
    end else begin
      pwr_q    <= pwr_d;
      flk_q    <= flk_d;
      sel_q    <= sel_d;
      code_q   <= code_d;
      period_q <= period_d;
      stream_q <= stream_d;
      map_q    <= map_d;
      fmode_q  <= fmode_d;
    end
  end

  assert_locked_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(period_q) && $stable(sel_q) && $stable(code_q)));

  assert_preset_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != TSEL_USER) |-> (code_q == '0));

  assert_pwr_clears_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_q |-> !flk_q);

endmodule

// File: rtl/flk_sample_timer.sv
module flk_sample_timer #(
  parameter int PERIOD_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                tick,
  input  logic [PERIOD_W-1:0] period,
  output logic                wrap
);

  logic [PERIOD_W-1:0] cnt_q, cnt_d;

  assign wrap = run & tick & (cnt_q == period);

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = wrap ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= period));

endmodule

// File: rtl/flk_frame_counter.sv
module flk_frame_counter #(
  parameter int CODE_W    = 2,
  parameter int BASE_LOG2 = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wrap,
  input  logic [CODE_W-1:0] code,
  input  logic              unlimited,
  output logic              sample_strobe,
  output logic              frame_start,
  output logic              frame_done
);

  localparam int CNT_W = BASE_LOG2 + (1 << CODE_W) - 1;

  logic [CNT_W-1:0] samp_q, samp_d;
  logic [CNT_W:0]   frame_len;
  logic [CNT_W-1:0] last_idx;
  logic             last, end_frame;
  logic             run_q;
  logic             strobe_d, start_d, done_d;

  assign frame_len = (CNT_W+1)'(1) << (BASE_LOG2 + int'(code));
  assign last_idx  = CNT_W'(frame_len - 1'b1);
  assign last      = (samp_q == last_idx);
  assign end_frame = wrap & last & ~unlimited;

  always_comb begin
    samp_d = samp_q;
    if (!run) begin
      samp_d = '0;
    end else if (wrap) begin
      samp_d = end_frame ? '0 : samp_q + 1'b1;
    end
    strobe_d = wrap;
    done_d   = end_frame;
    start_d  = run & (~run_q | end_frame);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q        <= '0;
      run_q         <= 1'b0;
      sample_strobe <= 1'b0;
      frame_start   <= 1'b0;
      frame_done    <= 1'b0;
    end else begin
      samp_q        <= samp_d;
      run_q         <= run;
      sample_strobe <= strobe_d;
      frame_start   <= start_d;
      frame_done    <= done_d;
    end
  end

  assert_done_with_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> sample_strobe);

  assert_done_starts_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> frame_start);

endmodule

// File: rtl/flk_timing_seq.sv
module flk_timing_seq
  import flk_timing_pkg::*;
#(
  parameter int PERIOD_W  = 10,
  parameter int LO_W      = 8,
  parameter int CODE_W    = 2,
  parameter int FMODE_W   = 3,
  parameter int DATA_W    = 8,
  parameter int BASE_P1   = 144,
  parameter int BASE_LOG2 = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [2:0]          cfg_addr,
  input  logic [DATA_W-1:0]   cfg_wdata,
  input  logic                mod_tick,
  output logic                sample_strobe,
  output logic                frame_start,
  output logic                frame_done,
  output logic [1:0]          rb_time_sel,
  output logic [CODE_W-1:0]   rb_count_code,
  output logic [PERIOD_W-1:0] rb_period,
  output logic                rb_pwr,
  output logic                rb_flk_en,
  output logic                rb_unlimited
);

  logic                pwr, flk, stream, map_fd, run, wrap, unlimited;
  tsel_e               sel;
  logic [CODE_W-1:0]   code;
  logic [PERIOD_W-1:0] period;
  logic [FMODE_W-1:0]  fmode;

  flk_cfg_regs #(
    .PERIOD_W(PERIOD_W), .LO_W(LO_W), .CODE_W(CODE_W),
    .FMODE_W(FMODE_W), .DATA_W(DATA_W), .BASE_P1(BASE_P1)
  ) cfg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_wdata),
    .pwr_q    (pwr),
    .flk_q    (flk),
    .sel_q    (sel),
    .code_q   (code),
    .period_q (period),
    .stream_q (stream),
    .map_q    (map_fd),
    .fmode_q  (fmode)
  );

  assign run       = pwr & flk;
  assign unlimited = (code == {CODE_W{1'b1}}) & stream & map_fd & (fmode != '0);

  flk_sample_timer #(.PERIOD_W(PERIOD_W)) timer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .tick   (mod_tick),
    .period (period),
    .wrap   (wrap)
  );

  flk_frame_counter #(.CODE_W(CODE_W), .BASE_LOG2(BASE_LOG2)) frame_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (run),
    .wrap          (wrap),
    .code          (code),
    .unlimited     (unlimited),
    .sample_strobe (sample_strobe),
    .frame_start   (frame_start),
    .frame_done    (frame_done)
  );

  assign rb_time_sel   = sel;
  assign rb_count_code = code;
  assign rb_period     = period;
  assign rb_pwr        = pwr;
  assign rb_flk_en     = flk;
  assign rb_unlimited  = unlimited;

  assert_unlimited_no_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(unlimited) |-> !frame_done);

  assert_strobe_needs_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> $past(pwr && flk));

endmodule

// File: tb/flk_timing_seq_tb.sv
`timescale 1ns/1ps
module flk_timing_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       mod_tick = 1'b0;
  logic       sample_strobe, frame_start, frame_done;
  logic [1:0] rb_time_sel, rb_count_code;
  logic [9:0] rb_period;
  logic       rb_pwr, rb_flk_en, rb_unlimited;

  int vectors = 0;
  int miscomp = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  flk_timing_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .mod_tick(mod_tick),
    .sample_strobe(sample_strobe), .frame_start(frame_start), .frame_done(frame_done),
    .rb_time_sel(rb_time_sel), .rb_count_code(rb_count_code), .rb_period(rb_period),
    .rb_pwr(rb_pwr), .rb_flk_en(rb_flk_en), .rb_unlimited(rb_unlimited)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    mod_tick  = 1'b0;
    cfg_wr    = 1'b1;
    cfg_addr  = 3'(addr);
    cfg_wdata = 8'(data);
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic chk_timing(input string tag, input int sel, input int code, input int per);
    chk({tag, " sel"}, int'(rb_time_sel), sel);
    chk({tag, " code"}, int'(rb_count_code), code);
    chk({tag, " period"}, int'(rb_period), per);
  endtask

  // R3 R4 R5: run from enable, compare each cycle against tick arithmetic
  task automatic run_seq(input int p, input int code, input bit unl,
                         input int gap, input int nticks);
    int t = 0;
    int cyc = 0;
    int n = 128 << code;
    bit exp_s, exp_d, exp_st;
    wr(0, 3);
    while (t < nticks) begin
      mod_tick = ((cyc % gap) == 0);
      @(posedge clk);
      if (mod_tick) t++;
      @(negedge clk);
      exp_s  = mod_tick && ((t % (p + 1)) == 0);
      exp_d  = exp_s && !unl && ((t % ((p + 1) * n)) == 0);
      exp_st = (cyc == 0) || exp_d;
      chk("R3 strobe", int'(sample_strobe), int'(exp_s));
      chk(unl ? "R6 done" : "R4 done", int'(frame_done), int'(exp_d));
      chk("R5 start", int'(frame_start), int'(exp_st));
      cyc++;
    end
    mod_tick = 1'b0;
    wr(0, 1);
  endtask

  task automatic idle_check(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      mod_tick = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R8 idle strobe", int'(sample_strobe), 0);
      chk("R8 idle start", int'(frame_start), 0);
      chk("R8 idle done", int'(frame_done), 0);
    end
    mod_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscomp++;
      vectors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk_timing("R9 reset", 1, 0, 287);
    chk("R9 pwr", int'(rb_pwr), 0);
    chk("R9 flk", int'(rb_flk_en), 0);
    chk("R9 unl", int'(rb_unlimited), 0);
    chk("R9 strobe", int'(sample_strobe | frame_start | frame_done), 0);

    // R1 presets overwrite user period and count
    for (int s = 0; s < 3; s++) begin
      wr(2, 8'hAA);
      wr(3, 1);
      wr(1, (3 << 2) | s);
      chk_timing("R1 preset", s, 0, (144 << s) - 1);
    end

    // R2 user period and count
    for (int hi = 0; hi < 4; hi++) begin
      for (int k = 0; k < 4; k++) begin
        int lo;
        lo = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 8'h7F : 8'hFF;
        wr(2, lo);
        wr(3, hi);
        wr(1, (hi << 2) | 3);
        chk_timing("R2 user", 3, hi, hi * 256 + lo);
      end
    end

    // R6 unlimited flag decode
    for (int code = 0; code < 4; code++) begin
      for (int c = 0; c < 8; c++) begin
        int fm;
        fm = c[2] ? 5 : 0;
        wr(4, (fm << 2) | (c[1] << 1) | c[0]);
        wr(1, (code << 2) | 3);
        chk("R6 flag", int'(rb_unlimited), int'(code == 3 && c == 7));
      end
    end

    // R3 R4 R5 user frames
    wr(4, 0);
    wr(2, 2); wr(3, 0); wr(1, (0 << 2) | 3);
    run_seq(2, 0, 0, 1, 800);
    idle_check(20);
    wr(2, 3); wr(1, (1 << 2) | 3);
    run_seq(3, 1, 0, 3, 1030);
    wr(2, 1); wr(1, (2 << 2) | 3);
    run_seq(1, 2, 0, 2, 1030);

    // R6 code 3 with FIFO mode zero: finite 1024 frames
    wr(4, 8'h03);
    wr(2, 0); wr(1, (3 << 2) | 3);
    run_seq(0, 3, 0, 1, 2100);
    // R6 unlimited run: no frame done
    wr(4, 8'h0B);
    chk("R6 flag run", int'(rb_unlimited), 1);
    run_seq(0, 3, 1, 1, 2100);
    wr(4, 0);

    // R7 writes locked while running
    wr(2, 2); wr(1, 3);
    wr(0, 3);
    wr(1, 0);
    wr(2, 8'hFF);
    wr(3, 3);
    chk_timing("R7 locked", 3, 0, 2);
    wr(0, 1);
    wr(1, 0);
    chk_timing("R7 unlocked", 0, 0, 143);

    // R4 preset 0 full frame (128 x 144 ticks)
    run_seq(143, 0, 0, 1, 18500);

    // R8 power bit clears flicker enable, stopping the sequence
    wr(0, 2);
    chk("R8 pwr", int'(rb_pwr), 0);
    chk("R8 flk", int'(rb_flk_en), 0);
    idle_check(20);
    wr(0, 3);
    chk("R8 flk set", int'(rb_flk_en), 1);
    wr(0, 0);
    chk("R8 flk cleared", int'(rb_flk_en), 0);
    idle_check(20);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

endmodule